// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of one SDRAM burst, one address per clock. A controller pulses `start_i` with a starting column, a burst-length code, an ordering bit and the access direction. From the next cycle the block presents one column per cycle on `col_o`, with `valid_o` high. `last_o` marks the final address.

Fixed-length bursts of 1, 2, 4 or 8 stay inside the aligned block that holds the start column. They wrap either by incrementing or by XOR with the beat index. A full-page burst walks all 256 columns in order and keeps wrapping until the controller requests a stop. A single-write mode shortens writes to one beat and leaves reads at the programmed length. A new start pulse cuts off any burst in flight.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous reset, `valid_o`, `last_o` and `col_o` are all zero.
- R2: All inputs are sampled at the clock edge where `start_i` is high. In the next cycle `valid_o` is 1 and `col_o` equals the sampled start column.
- R3: The burst-length code maps as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 give 1 beat. A fixed burst holds `valid_o` high for exactly that many consecutive cycles and then drops it.
- R4: With `order_i`=0, a fixed burst of length BL increments the low log2(BL) bits of the column by one each cycle, wrapping within that field. The upper bits keep the start column's value.
- R5: With `order_i`=1, a fixed burst of length BL outputs (start column XOR beat index) on the low log2(BL) bits. The upper bits are unchanged.
- R6: A full-page burst outputs start column plus beat index modulo 256 and ignores `order_i`. It runs without end until stopped.
- R7: If `stop_i` is high at an edge while a full-page burst is presenting a non-final address, the next cycle shows the following column with `last_o`=1, and `valid_o` drops after that. `stop_i` has no effect on fixed-length bursts or when idle.
- R8: `last_o` is high only with `valid_o`. In fixed bursts it is high only on the final address.
- R9: When `single_wr_i`=1 and `wr_i`=1 the burst is 1 beat whatever the code. Reads, and writes with `single_wr_i`=0, use the programmed length.
- R10: A start pulse during an active burst abandons that burst. The next cycle shows the new burst's first column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst (one-cycle pulse) |
| start_col_i | input | 8 | First column of the burst |
| bl_code_i | input | 3 | Burst-length code (see R3) |
| order_i | input | 1 | 0 = sequential wrap, 1 = interleaved wrap |
| wr_i | input | 1 | 1 = the burst is a write |
| single_wr_i | input | 1 | 1 = writes use one beat |
| stop_i | input | 1 | Terminate a full-page burst |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | `col_o` holds a burst address |
| last_o | output | 1 | Final address of the burst |

## Verification
Start columns are chosen to sit mid-block, so a sequencer that carried into the upper bits, or that took the start column as index zero, would print visibly wrong addresses. Interleaved bursts use a start whose low bits make XOR and add differ. A full-page run crosses 255 to 0, which catches a counter that saturates or stops. Stop pulses are also sent to fixed bursts and to an idle block, where a design that obeyed them would cut the burst short or raise `valid_o`. A restart in mid-burst shows whether stale beats leak through. Single-write is tried for both directions, to catch an override that also shortened reads.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_FULL = '1;
endpackage

// File: rtl/bseq_len_decode.sv
module bseq_len_decode
  import bseq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_LG = 3
) (
  input  logic [CODE_W-1:0] bl_code,
  input  logic              wr,
  input  logic              single_wr,
  output logic [COL_W-1:0]  mask,
  output logic              full
);
  logic [COL_W-1:0] mask_tab [MAX_LG+1];

  for (genvar k = 0; k <= MAX_LG; k++) begin : g_mask
    assign mask_tab[k] = COL_W'((1 << k) - 1);
  end

  always_comb begin
    mask = '0;
    full = 1'b0;
    if (wr && single_wr) begin
      mask = '0;
      full = 1'b0;
    end else if (bl_code == CODE_FULL) begin
      mask = '1;
      full = 1'b1;
    end else begin
      for (int k = 0; k <= MAX_LG; k++) begin
        if (bl_code == CODE_W'(k)) mask = mask_tab[k];
      end
    end
  end

  // R9
  always_comb begin
    if (wr && single_wr) single_wr_len_chk: assert (mask == '0 && !full);
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  input  logic             full,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (full) begin
      low  = base + idx;
      addr = low;
    end else begin
      low  = ilv ? (base ^ idx) : (base + idx);
      addr = (base & ~mask) | (low & mask);
    end
  end
endmodule

// File: rtl/bseq_step_ctrl.sv
module bseq_step_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             ilv_in,
  input  logic             stop,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q, mask_q, idx_q;
  logic             full_q, ilv_q;

  logic [COL_W-1:0] sel_base, sel_mask, sel_idx, nxt_addr;
  logic             sel_full, sel_ilv, step;

  assign step     = valid_o && !last_o && !start;
  assign sel_base = start ? start_col : base_q;
  assign sel_mask = start ? mask_in   : mask_q;
  assign sel_full = start ? full_in   : full_q;
  assign sel_ilv  = start ? (ilv_in && !full_in) : ilv_q;
  assign sel_idx  = start ? '0 : idx_q + COL_W'(1);

  bseq_addr_gen #(.COL_W(COL_W)) u_addr (
    .base (sel_base),
    .idx  (sel_idx),
    .mask (sel_mask),
    .ilv  (sel_ilv),
    .full (sel_full),
    .addr (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      idx_q   <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (start) begin
      base_q  <= start_col;
      mask_q  <= mask_in;
      full_q  <= full_in;
      ilv_q   <= ilv_in && !full_in;
      idx_q   <= '0;
      col_o   <= nxt_addr;
      valid_o <= 1'b1;
      last_o  <= !full_in && (mask_in == '0);
    end else if (step) begin
      idx_q   <= sel_idx;
      col_o   <= nxt_addr;
      last_o  <= full_q ? stop : (sel_idx == mask_q);
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

  // R8
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R3
  ends_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && !start) |=> !valid_o);

  // R2
  start_loads_col_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (valid_o && col_o == $past(start_col)));

  // R6
  full_page_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !start && full_q) |=> (col_o == $past(col_o) + COL_W'(1)));

  // R4
  seq_upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !start && !full_q) |=> (((col_o ^ $past(col_o)) & ~mask_q) == '0));

  // R7
  stop_fixed_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !start && !full_q && (idx_q + COL_W'(1) != mask_q)) |=> !last_o);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_LG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              order_i,
  input  logic              wr_i,
  input  logic              single_wr_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;

  bseq_len_decode #(.COL_W(COL_W), .MAX_LG(MAX_LG)) u_dec (
    .bl_code   (bl_code_i),
    .wr        (wr_i),
    .single_wr (single_wr_i),
    .mask      (dec_mask),
    .full      (dec_full)
  );

  bseq_step_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .start_col (start_col_i),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .ilv_in    (order_i == ORD_ILV),
    .stop      (stop_i),
    .col_o     (col_o),
    .valid_o   (valid_o),
    .last_o    (last_o)
  );
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       order_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       single_wr_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .order_i(order_i), .wr_i(wr_i),
    .single_wr_i(single_wr_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic check(input string req, input logic [7:0] c, input logic v, input logic l);
    n_chk++;
    if (col_o !== c || valid_o !== v || last_o !== l) begin
      n_bad++;
      $display("FAIL %s: got col=%02h v=%0b l=%0b, expected col=%02h v=%0b l=%0b",
               req, col_o, valid_o, last_o, c, v, l);
    end
  endtask

  task automatic check_idle(input string req);
    n_chk++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got v=%0b l=%0b, expected v=0 l=0", req, valid_o, last_o);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] b, input int idx,
                                         input int lg, input bit full, input bit ilv);
    logic [7:0] m, lo;
    if (full) return 8'(int'(b) + idx);
    m  = 8'((1 << lg) - 1);
    lo = ilv ? (b ^ 8'(idx)) : 8'(int'(b) + idx);
    return (b & ~m) | (lo & m);
  endfunction

  task automatic issue(input logic [7:0] c, input logic [2:0] code, input bit ilv,
                       input bit wr, input bit swr);
    start_i = 1'b1; start_col_i = c; bl_code_i = code;
    order_i = ilv; wr_i = wr; single_wr_i = swr;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Runs a burst and checks every beat; stop is pulsed after beat stop_at.
  task automatic burst(input string req, input logic [7:0] c, input logic [2:0] code,
                       input bit ilv, input bit wr, input bit swr, input int stop_at);
    int  lg;
    bit  full;
    int  n;
    full = (code == 3'd7);
    if (wr && swr) begin lg = 0; full = 0; end
    else if (full) lg = 8;
    else if (code <= 3'd3) lg = int'(code);
    else lg = 0;
    n = full ? stop_at + 2 : (1 << lg);
    @(negedge clk);
    issue(c, code, ilv, wr, swr);
    for (int i = 0; i < n; i++) begin
      check(req, exp_col(c, i, lg, full, ilv), 1'b1, (i == n - 1));
      stop_i = (i == stop_at);
      @(negedge clk);
    end
    stop_i = 1'b0;
    check_idle(req);
  endtask

  task automatic t_reset;
    check("R1", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_lengths;
    burst("R3 R4 bl8 seq", 8'h35, 3'd3, 0, 0, 0, -1);
    burst("R4 bl4 seq",    8'h2E, 3'd2, 0, 0, 0, -1);
    burst("R3 bl2",        8'h71, 3'd1, 0, 0, 0, -1);
    burst("R3 bl1",        8'hC4, 3'd0, 0, 0, 0, -1);
    burst("R3 reserved",   8'h5A, 3'd5, 0, 0, 0, -1);
  endtask

  task automatic t_interleave;
    burst("R5 bl8 ilv", 8'h35, 3'd3, 1, 0, 0, -1);
    burst("R5 bl4 ilv", 8'hA6, 3'd2, 1, 0, 0, -1);
  endtask

  task automatic t_full_page;
    burst("R6 R7 full page", 8'hFD, 3'd7, 1, 0, 0, 299);
    burst("R7 full quick stop", 8'h10, 3'd7, 0, 1, 0, 0);
  endtask

  task automatic t_stop_ignored;
    burst("R7 stop on fixed", 8'h42, 3'd3, 0, 0, 0, 2);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check_idle("R7 stop idle");
    @(negedge clk);
    check_idle("R7 stop idle");
  endtask

  task automatic t_single_write;
    burst("R9 single write", 8'h33, 3'd3, 0, 1, 1, -1);
    burst("R9 read ignores single", 8'h33, 3'd3, 0, 0, 1, -1);
    burst("R9 burst write", 8'h33, 3'd2, 0, 1, 0, -1);
  endtask

  task automatic t_restart;
    @(negedge clk);
    issue(8'h14, 3'd3, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      check("R10 first", exp_col(8'h14, i, 3, 0, 0), 1'b1, 1'b0);
      if (i < 2) @(negedge clk);
    end
    issue(8'h81, 3'd1, 1, 0, 0);
    check("R10 new", 8'h81, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 new", 8'h80, 1'b1, 1'b1);
    @(negedge clk);
    check_idle("R10 end");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lengths();
    t_interleave();
    t_full_page();
    t_stop_ignored();
    t_single_write();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule